// File: doc/BRIEF.md
# Paired Byte FIFO with Threshold Ready Flags

This block holds the transmit and receive bytes of a serial byte engine between a register-side access port and the engine itself. The transmit FIFO is filled from the register side and drained one byte at a time by the engine. The receive FIFO is filled one byte at a time by the engine and drained from the register side. A register-side access moves either a single byte or a packed 32-bit word of four bytes, and the two kinds may be mixed freely.

Each FIFO raises a ready flag, which serves as both the interrupt status and the DMA request, when its free space (transmit) or its stored count (receive) reaches a threshold. The threshold is chosen per side as one entry or four entries. Each FIFO has its own flush command, and both may be given in the same cycle. When the FIFO function is switched off, each side behaves as a single holding register. Register-side accesses that cannot be served are dropped and flagged. Each side's fill level can be read back.

Top module: `bytefifo_pair`

## Requirements
- R1: After reset both levels are 0, `rx_rdata` is 0, `tx_ready` is 1, `rx_ready` is 0, `eng_tx_valid` and `eng_rx_full` are 0, and all error pulses are 0.
- R2: Bytes written one at a time appear at `eng_tx_data` in write order. `eng_tx_valid` is high while the transmit FIFO holds data, and each `eng_tx_pop` removes the head byte.
- R3: A 32-bit transmit write (`tx_wide`=1, FIFO on) stores four bytes, least significant byte first. Bits [7:0] reach the engine first and bits [31:24] last.
- R4: A transmit write is accepted only if the free space is at least the number of bytes it carries (4 for a wide write with the FIFO on, otherwise 1). A refused write is dropped, leaves the level unchanged, and raises `tx_err` for one cycle starting one clock after the write.
- R5: `tx_ready` is 1 exactly when the free transmit entries are at least 4 (`tx_thr4`=1 with the FIFO on) or at least 1 (otherwise).
- R6: `rx_ready` is 1 exactly when the stored receive entries are at least 4 (`rx_thr4`=1 with the FIFO on) or at least 1 (otherwise).
- R7: `eng_rx_push` stores `eng_rx_data` unless the receive FIFO is full. `eng_rx_full` is 1 at full capacity. A push while full is dropped and raises `rx_ovr` for one cycle, one clock later.
- R8: An accepted byte read puts the oldest byte on `rx_rdata[7:0]` with zero upper bits, one clock after the read. An accepted wide read (FIFO on) returns the four oldest bytes, with the oldest in [7:0].
- R9: A read asking for more bytes than are stored pops nothing, leaves `rx_rdata` unchanged, and raises `rx_err` for one cycle, one clock later.
- R10: `flush_tx` empties the transmit FIFO and `flush_rx` empties the receive FIFO, each independently or together. An access in the same cycle as its side's flush is discarded without an error.
- R11: With `fifo_en`=0 each side holds one byte. A wide access moves only bits [7:0], and both thresholds act as one entry. Any change of `fifo_en` empties both FIFOs.
- R12: `tx_level` and `rx_level` report the stored byte count of each FIFO, from 0 up to DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | 1: full FIFO depth and wide accesses; 0: single holding byte |
| tx_thr4 | input | 1 | Transmit threshold select: 1 = four free entries, 0 = one |
| rx_thr4 | input | 1 | Receive threshold select: 1 = four stored entries, 0 = one |
| flush_tx | input | 1 | Empty the transmit FIFO |
| flush_rx | input | 1 | Empty the receive FIFO |
| tx_wr | input | 1 | Register-side transmit write strobe |
| tx_wide | input | 1 | Write size: 1 = 32-bit word, 0 = byte |
| tx_wdata | input | 32 | Write data, byte in [7:0] |
| rx_rd | input | 1 | Register-side receive read strobe |
| rx_wide | input | 1 | Read size: 1 = 32-bit word, 0 = byte |
| rx_rdata | output | 32 | Registered read data |
| tx_ready | output | 1 | Transmit threshold reached (interrupt/DMA request) |
| rx_ready | output | 1 | Receive threshold reached (interrupt/DMA request) |
| tx_level | output | $clog2(DEPTH)+1 | Transmit fill level |
| rx_level | output | $clog2(DEPTH)+1 | Receive fill level |
| tx_err | output | 1 | Pulse: transmit write refused |
| rx_err | output | 1 | Pulse: receive read found too few bytes |
| rx_ovr | output | 1 | Pulse: engine push into a full receive FIFO |
| eng_tx_valid | output | 1 | Transmit FIFO holds a byte for the engine |
| eng_tx_data | output | 8 | Head byte of the transmit FIFO |
| eng_tx_pop | input | 1 | Engine takes the head byte |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_full | output | 1 | Receive FIFO at capacity |

## Verification
The bench uses a depth of 8 and, for both threshold settings, fills each FIFO to every level from empty to full. At each level it checks the ready flag against the free or stored count, then drains the FIFO, comparing the byte order against the values written. Wide writes and wide reads are tried at every starting level, which locates the exact boundary where the four-entry room or content check flips from accept to refuse. Separate runs cover full and empty edges, flushes on one side, on both sides and together with an access, and the single-entry mode, where a wide access must move only one byte.

// File: rtl/fifo_pkg.sv
// Package: shared byte/word types and lane constants for the paired byte FIFO.
// Assumes byte lanes of 8 bits packed four to a 32-bit word.
package fifo_pkg;
    localparam int LANES = 4;
    typedef logic [7:0]  byte_t;
    typedef logic [31:0] word_t;
endpackage

// File: rtl/byte_fifo_core.sv
// Module: byte_fifo_core
// Circular byte store that accepts up to four bytes and releases up to four
// bytes per cycle. The caller decides acceptance; this module never refuses.
// Assumes DEPTH is a power of two and at least 8, and that push_cnt/pop_cnt
// never exceed the room or content the caller has checked.
module byte_fifo_core
    import fifo_pkg::*;
#(
    parameter int  DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [2:0]    push_cnt,
    input  word_t         push_word,
    input  logic [2:0]    pop_cnt,
    output word_t         peek_word,
    output logic [LW-1:0] level
);
    byte_t         mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    // Write the accepted byte lanes at consecutive slots from the write pointer.
    always_ff @(posedge clk) begin
        if (!clear) begin
            for (int i = 0; i < LANES; i++) begin
                if (3'(i) < push_cnt) begin
                    mem[wr_ptr + AW'(i)] <= push_word[8*i +: 8];
                end
            end
        end
    end

    // Advance pointers and the level; reset or clear empties the store.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(push_cnt);
            rd_ptr <= rd_ptr + AW'(pop_cnt);
            level  <= level + LW'(push_cnt) - LW'(pop_cnt);
        end
    end

    // Present the four oldest bytes, oldest in the lowest lane.
    for (genvar g = 0; g < LANES; g++) begin : g_peek
        assign peek_word[8*g +: 8] = mem[rd_ptr + AW'(g)];
    end
endmodule

// File: rtl/fill_threshold.sv
// Module: fill_threshold
// Compares either the free space (COUNT_FREE=1) or the stored count
// (COUNT_FREE=0) against a threshold of one or four entries.
// Assumes level never exceeds cap while the result is used.
module fill_threshold #(
    parameter int LW         = 5,
    parameter bit COUNT_FREE = 1'b0
) (
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] cap,
    input  logic          four_sel,
    output logic          ready
);
    logic [LW-1:0] amount;
    logic [LW-1:0] need;

    // Pick the measured quantity and the threshold, then compare.
    always_comb begin
        amount = COUNT_FREE ? (cap - level) : level;
        need   = four_sel ? LW'(4) : LW'(1);
        ready  = (amount >= need);
    end
endmodule

// File: rtl/bytefifo_pair.sv
// Module: bytefifo_pair
// Transmit and receive byte FIFOs between a register-side port and a serial
// byte engine, with one/four-entry ready thresholds, byte or packed-word
// access, independent flushes and a single-entry mode when fifo_en is low.
// Assumes DEPTH is a power of two, at least 8. Room and content checks use
// the level at the start of the cycle, so a same-cycle opposite operation
// never makes room or content available early.
module bytefifo_pair
    import fifo_pkg::*;
#(
    parameter int  DEPTH = 16,
    localparam int LW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          tx_thr4,
    input  logic          rx_thr4,
    input  logic          flush_tx,
    input  logic          flush_rx,
    input  logic          tx_wr,
    input  logic          tx_wide,
    input  logic [31:0]   tx_wdata,
    input  logic          rx_rd,
    input  logic          rx_wide,
    output logic [31:0]   rx_rdata,
    output logic          tx_ready,
    output logic          rx_ready,
    output logic [LW-1:0] tx_level,
    output logic [LW-1:0] rx_level,
    output logic          tx_err,
    output logic          rx_err,
    output logic          rx_ovr,
    output logic          eng_tx_valid,
    output logic [7:0]    eng_tx_data,
    input  logic          eng_tx_pop,
    input  logic          eng_rx_push,
    input  logic [7:0]    eng_rx_data,
    output logic          eng_rx_full
);
    logic          en_q;
    logic          clr_tx, clr_rx;
    logic [LW-1:0] cap;
    logic [2:0]    tx_need, rx_need;
    logic          tx_ok, tx_rej, rx_ok, rx_short, erx_ok, erx_rej;
    logic [2:0]    tx_push_cnt, tx_pop_cnt, rx_push_cnt, rx_pop_cnt;
    word_t         tx_peek, rx_peek;

    // Remember the mode so that any change of fifo_en empties both sides.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= fifo_en;
    end

    // Decide per side what is cleared, accepted or refused this cycle.
    always_comb begin
        clr_tx   = flush_tx | (fifo_en ^ en_q);
        clr_rx   = flush_rx | (fifo_en ^ en_q);
        cap      = fifo_en ? LW'(DEPTH) : LW'(1);
        tx_need  = (tx_wide && fifo_en) ? 3'd4 : 3'd1;
        rx_need  = (rx_wide && fifo_en) ? 3'd4 : 3'd1;
        tx_ok    = tx_wr && !clr_tx && ((cap - tx_level) >= LW'(tx_need));
        tx_rej   = tx_wr && !clr_tx && !tx_ok;
        rx_ok    = rx_rd && !clr_rx && (rx_level >= LW'(rx_need));
        rx_short = rx_rd && !clr_rx && !rx_ok;
        erx_ok   = eng_rx_push && !clr_rx && (rx_level < cap);
        erx_rej  = eng_rx_push && !clr_rx && !erx_ok;
        tx_push_cnt = tx_ok ? tx_need : 3'd0;
        tx_pop_cnt  = (eng_tx_pop && !clr_tx && (tx_level != '0)) ? 3'd1 : 3'd0;
        rx_push_cnt = erx_ok ? 3'd1 : 3'd0;
        rx_pop_cnt  = rx_ok ? rx_need : 3'd0;
    end

    byte_fifo_core #(.DEPTH(DEPTH)) u_tx_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clr_tx),
        .push_cnt  (tx_push_cnt),
        .push_word (tx_wdata),
        .pop_cnt   (tx_pop_cnt),
        .peek_word (tx_peek),
        .level     (tx_level)
    );

    byte_fifo_core #(.DEPTH(DEPTH)) u_rx_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clr_rx),
        .push_cnt  (rx_push_cnt),
        .push_word ({24'h0, eng_rx_data}),
        .pop_cnt   (rx_pop_cnt),
        .peek_word (rx_peek),
        .level     (rx_level)
    );

    fill_threshold #(.LW(LW), .COUNT_FREE(1'b1)) u_tx_thr (
        .level    (tx_level),
        .cap      (cap),
        .four_sel (tx_thr4 & fifo_en),
        .ready    (tx_ready)
    );

    fill_threshold #(.LW(LW), .COUNT_FREE(1'b0)) u_rx_thr (
        .level    (rx_level),
        .cap      (cap),
        .four_sel (rx_thr4 & fifo_en),
        .ready    (rx_ready)
    );

    // Capture read data on an accepted read; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_rdata <= '0;
        end else if (rx_ok) begin
            rx_rdata <= (rx_need == 3'd4) ? rx_peek : {24'h0, rx_peek[7:0]};
        end
    end

    // Register one-cycle error pulses for refused accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_err <= 1'b0;
            rx_err <= 1'b0;
            rx_ovr <= 1'b0;
        end else begin
            tx_err <= tx_rej;
            rx_err <= rx_short;
            rx_ovr <= erx_rej;
        end
    end

    assign eng_tx_valid = (tx_level != '0);
    assign eng_tx_data  = tx_peek[7:0];
    assign eng_rx_full  = (rx_level >= cap);
endmodule

// File: rtl/bytefifo_pair_chk.sv
// Module: bytefifo_pair_chk
// Property checker for bytefifo_pair, attached by bind below.
// Assumes synchronous active-low reset on rst_n.
module bytefifo_pair_chk #(
    parameter int  DEPTH = 16,
    localparam int LW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          flush_tx,
    input logic          flush_rx,
    input logic          tx_wr,
    input logic          tx_err,
    input logic          rx_err,
    input logic          rx_ovr,
    input logic [31:0]   rx_rdata,
    input logic [LW-1:0] tx_level,
    input logic [LW-1:0] rx_level,
    input logic          eng_rx_full
);
    // R12: levels stay within the store depth
    a_r12_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH)));

    // R10: a transmit flush empties the transmit side
    a_r10_flush_tx: assert property (@(posedge clk) disable iff (!rst_n)
        flush_tx |=> (tx_level == '0));

    // R10: a receive flush empties the receive side
    a_r10_flush_rx: assert property (@(posedge clk) disable iff (!rst_n)
        flush_rx |=> (rx_level == '0));

    // R9: a short read leaves the read data untouched
    a_r9_short_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |-> $stable(rx_rdata));

    // R4: a write refusal only follows a write
    a_r4_reject_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err |-> $past(tx_wr));

    // R7: an overrun only follows a full receive side
    a_r7_ovr_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovr |-> $past(eng_rx_full));

    // R11: single-entry mode holds at most one byte per side
    a_r11_single_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && $past(!fifo_en)) |-> ((tx_level <= LW'(1)) && (rx_level <= LW'(1))));
endmodule

bind bytefifo_pair bytefifo_pair_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_en     (fifo_en),
    .flush_tx    (flush_tx),
    .flush_rx    (flush_rx),
    .tx_wr       (tx_wr),
    .tx_err      (tx_err),
    .rx_err      (rx_err),
    .rx_ovr      (rx_ovr),
    .rx_rdata    (rx_rdata),
    .tx_level    (tx_level),
    .rx_level    (rx_level),
    .eng_rx_full (eng_rx_full)
);

// File: tb/bytefifo_pair_tb_top.sv
// Bench: sweeps fill levels, thresholds and access sizes on a depth-8 build.
module bytefifo_pair_tb_top;
    localparam int DEP = 8;
    localparam int LW  = $clog2(DEP) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_en = 1'b1;
    logic          tx_thr4 = 1'b0, rx_thr4 = 1'b0;
    logic          flush_tx = 1'b0, flush_rx = 1'b0;
    logic          tx_wr = 1'b0, tx_wide = 1'b0;
    logic [31:0]   tx_wdata = '0;
    logic          rx_rd = 1'b0, rx_wide = 1'b0;
    logic [31:0]   rx_rdata;
    logic          tx_ready, rx_ready;
    logic [LW-1:0] tx_level, rx_level;
    logic          tx_err, rx_err, rx_ovr;
    logic          eng_tx_valid;
    logic [7:0]    eng_tx_data;
    logic          eng_tx_pop = 1'b0;
    logic          eng_rx_push = 1'b0;
    logic [7:0]    eng_rx_data = '0;
    logic          eng_rx_full;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bytefifo_pair #(.DEPTH(DEP)) dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .tx_thr4(tx_thr4), .rx_thr4(rx_thr4),
        .flush_tx(flush_tx), .flush_rx(flush_rx),
        .tx_wr(tx_wr), .tx_wide(tx_wide), .tx_wdata(tx_wdata),
        .rx_rd(rx_rd), .rx_wide(rx_wide), .rx_rdata(rx_rdata),
        .tx_ready(tx_ready), .rx_ready(rx_ready),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_err(tx_err), .rx_err(rx_err), .rx_ovr(rx_ovr),
        .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data), .eng_tx_pop(eng_tx_pop),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .eng_rx_full(eng_rx_full)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_byte(input logic [7:0] b);
        tx_wr = 1'b1; tx_wide = 1'b0; tx_wdata = {24'hA5A5A5, b};
        tick();
        tx_wr = 1'b0;
    endtask

    task automatic wr_word(input logic [31:0] w);
        tx_wr = 1'b1; tx_wide = 1'b1; tx_wdata = w;
        tick();
        tx_wr = 1'b0; tx_wide = 1'b0;
    endtask

    task automatic pop_chk(input logic [7:0] exp, input string req);
        check(req, {24'h0, eng_tx_data}, {24'h0, exp});
        eng_tx_pop = 1'b1;
        tick();
        eng_tx_pop = 1'b0;
    endtask

    task automatic eng_push(input logic [7:0] b);
        eng_rx_push = 1'b1; eng_rx_data = b;
        tick();
        eng_rx_push = 1'b0;
    endtask

    task automatic rd(input logic wide);
        rx_rd = 1'b1; rx_wide = wide;
        tick();
        rx_rd = 1'b0; rx_wide = 1'b0;
    endtask

    task automatic do_flush(input logic t, input logic r);
        flush_tx = t; flush_rx = r;
        tick();
        flush_tx = 1'b0; flush_rx = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R1: reset state
        check("R1 tx_level", 32'(tx_level), 0);
        check("R1 rx_level", 32'(rx_level), 0);
        check("R1 rx_rdata", rx_rdata, 0);
        check("R1 tx_ready", 32'(tx_ready), 1);
        check("R1 rx_ready", 32'(rx_ready), 0);
        check("R1 valid/full", {30'h0, eng_tx_valid, eng_rx_full}, 0);
        check("R1 err pulses", {29'h0, tx_err, rx_err, rx_ovr}, 0);

        // R2 R5 R6 R7 R8 R12: every fill level under both thresholds
        for (int thr = 0; thr < 2; thr++) begin
            tx_thr4 = thr[0]; rx_thr4 = thr[0];
            for (int n = 0; n <= DEP; n++) begin
                do_flush(1'b1, 1'b1);
                for (int i = 0; i < n; i++) wr_byte(8'(n*16 + i));
                check("R12 tx_level", 32'(tx_level), 32'(n));
                check("R5 tx_ready", 32'(tx_ready), 32'((DEP - n) >= (thr != 0 ? 4 : 1)));
                check("R2 eng_tx_valid", 32'(eng_tx_valid), 32'(n != 0));
                for (int i = 0; i < n; i++) pop_chk(8'(n*16 + i), "R2 order");
                check("R2 drained", 32'(tx_level), 0);
                for (int i = 0; i < n; i++) eng_push(8'(n*8 + i + 1));
                check("R12 rx_level", 32'(rx_level), 32'(n));
                check("R6 rx_ready", 32'(rx_ready), 32'(n >= (thr != 0 ? 4 : 1)));
                check("R7 eng_rx_full", 32'(eng_rx_full), 32'(n == DEP));
                for (int i = 0; i < n; i++) begin
                    rd(1'b0);
                    check("R8 byte read", rx_rdata, 32'(8'(n*8 + i + 1)));
                end
            end
        end
        tx_thr4 = 1'b0; rx_thr4 = 1'b0;

        // R3 R4: wide write at every starting level
        for (int k = 0; k <= DEP; k++) begin
            logic acc;
            acc = ((DEP - k) >= 4);
            do_flush(1'b1, 1'b1);
            for (int i = 0; i < k; i++) wr_byte(8'(i));
            wr_word({8'hD4, 8'hC3, 8'hB2, 8'(8'hA1 ^ k)});
            check("R4 tx_err", 32'(tx_err), 32'(!acc));
            check("R4 level", 32'(tx_level), 32'(k + (acc ? 4 : 0)));
            for (int i = 0; i < k; i++) pop_chk(8'(i), "R3 prior bytes");
            if (acc) begin
                pop_chk(8'(8'hA1 ^ k), "R3 lane0 first");
                pop_chk(8'hB2, "R3 lane1");
                pop_chk(8'hC3, "R3 lane2");
                pop_chk(8'hD4, "R3 lane3 last");
            end
        end

        // R4: byte write into a full transmit FIFO
        do_flush(1'b1, 1'b0);
        for (int i = 0; i < DEP; i++) wr_byte(8'(i + 8'h40));
        wr_byte(8'hFF);
        check("R4 full byte err", 32'(tx_err), 1);
        check("R4 full level", 32'(tx_level), 32'(DEP));
        for (int i = 0; i < DEP; i++) pop_chk(8'(i + 8'h40), "R4 contents kept");

        // R8 R9: wide read at every starting level
        for (int k = 0; k <= DEP; k++) begin
            do_flush(1'b0, 1'b1);
            for (int i = 0; i < k; i++) eng_push(8'(k*16 + i));
            prev = rx_rdata;
            rd(1'b1);
            if (k >= 4) begin
                check("R8 wide read", rx_rdata,
                      {8'(k*16 + 3), 8'(k*16 + 2), 8'(k*16 + 1), 8'(k*16)});
                check("R8 wide level", 32'(rx_level), 32'(k - 4));
                check("R8 no err", 32'(rx_err), 0);
            end else begin
                check("R9 held data", rx_rdata, prev);
                check("R9 rx_err", 32'(rx_err), 1);
                check("R9 level kept", 32'(rx_level), 32'(k));
            end
        end

        // R9: byte read from empty
        do_flush(1'b0, 1'b1);
        prev = rx_rdata;
        rd(1'b0);
        check("R9 empty byte data", rx_rdata, prev);
        check("R9 empty byte err", 32'(rx_err), 1);

        // R7: engine push into a full receive FIFO
        for (int i = 0; i < DEP; i++) eng_push(8'(i + 8'h70));
        eng_push(8'hEE);
        check("R7 rx_ovr", 32'(rx_ovr), 1);
        check("R7 level", 32'(rx_level), 32'(DEP));
        for (int i = 0; i < DEP; i++) begin
            rd(1'b0);
            check("R7 contents kept", rx_rdata, 32'(8'(i + 8'h70)));
        end

        // R10: independent and joint flushes
        for (int i = 0; i < 3; i++) begin wr_byte(8'(i)); eng_push(8'(i)); end
        do_flush(1'b1, 1'b0);
        check("R10 tx only tx", 32'(tx_level), 0);
        check("R10 tx only rx", 32'(rx_level), 3);
        do_flush(1'b0, 1'b1);
        check("R10 rx only", 32'(rx_level), 0);
        for (int i = 0; i < 2; i++) begin wr_byte(8'(i)); eng_push(8'(i)); end
        do_flush(1'b1, 1'b1);
        check("R10 both", {16'(tx_level), 16'(rx_level)}, 0);
        tx_wr = 1'b1; tx_wdata = 32'h5; flush_tx = 1'b1;
        tick();
        tx_wr = 1'b0; flush_tx = 1'b0;
        check("R10 write with flush level", 32'(tx_level), 0);
        check("R10 write with flush err", 32'(tx_err), 0);

        // R11: single-entry mode
        fifo_en = 1'b0; tx_thr4 = 1'b1; rx_thr4 = 1'b1;
        for (int i = 0; i < 3; i++) wr_byte(8'(i));
        fifo_en = 1'b1;
        tick();
        fifo_en = 1'b0;
        tick();
        check("R11 mode change flushes", 32'(tx_level), 0);
        check("R11 tx_ready thr one", 32'(tx_ready), 1);
        wr_word(32'h11223344);
        check("R11 wide write one byte", 32'(tx_level), 1);
        check("R11 wide write no err", 32'(tx_err), 0);
        wr_byte(8'h99);
        check("R11 second write err", 32'(tx_err), 1);
        check("R11 tx_ready none free", 32'(tx_ready), 0);
        pop_chk(8'h44, "R11 low byte only");
        eng_push(8'h5A);
        check("R11 rx full at one", 32'(eng_rx_full), 1);
        check("R11 rx_ready thr one", 32'(rx_ready), 1);
        eng_push(8'h5B);
        check("R11 rx overrun", 32'(rx_ovr), 1);
        rd(1'b1);
        check("R11 wide read one byte", rx_rdata, 32'h5A);
        check("R11 rx emptied", 32'(rx_level), 0);
        fifo_en = 1'b1;
        tick();
        check("R11 re-enable empty", {16'(tx_level), 16'(rx_level)}, 0);

        done = 1'b1;
        finish_run();
    end
endmodule